// File: doc/BRIEF.md
# Processor Power-State Sequencer

This block moves a processor core between its running state and a set of low-power states. Software selects a target state by writing a code. The block then raises a quiesce request to the system and waits for the system's acknowledge. Only after that does it gate the core's clock domains. The domains are instruction fetch, functional units, bus snooping, timers and debug. The block produces an enable level for each domain, and it shows the current state as a three-bit code.

In the nap state the core can still serve bus snoops. A snoop request moves it to doze, where snooping is enabled, and the block returns to nap when the request drops. Sleep turns off every domain and ignores snoop requests. In deep sleep the block also tells the system that the PLL, and then the system clock, may be stopped. A wake event returns the core to run. The wake events are an interrupt, a machine check or a reset request. When the core leaves deep sleep, it first spends a fixed lock-wait period with all domains off. A software-held level selects a half-rate core clock, and the block samples that level only while the core is running.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset the state code is 0 (run), all five enables are high, and quiesce request, PLL-stop permission and half-rate select are low.
- R2: In run, a command write with code 1 (nap), 2 (sleep) or 3 (deep sleep) moves the block to state 1 (await acknowledge) at the next edge, with quiesce request high and only fetch disabled. A write with code 0 has no effect.
- R3: The block leaves state 1 for the requested state (2 nap, 4 sleep, 5 deep sleep) only at an edge where acknowledge is high. Otherwise it stays in state 1.
- R4: In nap, only the timer and debug enables are high, and quiesce request stays high.
- R5: In nap, a snoop request moves the block to state 3 (doze) with the snoop enable added. In doze, a low snoop request moves it back to nap.
- R6: In sleep (state 4) all enables are low, and a snoop request has no effect.
- R7: PLL-stop permission is high in deep sleep (state 5) and in no other state. All enables are low there.
- R8: A wake event (interrupt, machine check or reset request) in states 1, 2, 3 or 4 returns the block to run at the next edge, with quiesce request low.
- R9: A wake event in deep sleep enters state 6 (relock). The block stays there for exactly LOCK_CYCLES cycles with all enables and quiesce request low, and then returns to run.
- R10: The half-rate select follows the half-rate request only while in run. It holds its value in every other state, except that entering relock clears it.
- R11: Command writes made in any state other than run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-side clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 2 | Requested state: 0 run, 1 nap, 2 sleep, 3 deep sleep |
| half_req | input | 1 | Software request for half-rate core clock |
| qack | input | 1 | Quiesce acknowledge from system |
| snoop_req | input | 1 | System asks the core to snoop |
| wake_irq | input | 1 | Interrupt wake event |
| wake_mchk | input | 1 | Machine-check wake event |
| wake_rst | input | 1 | Reset-request wake event |
| qreq | output | 1 | Quiesce request to system |
| en_fetch | output | 1 | Instruction fetch clock enable |
| en_units | output | 1 | Functional unit clock enable |
| en_snoop | output | 1 | Bus snoop clock enable |
| en_timer | output | 1 | Timer clock enable |
| en_debug | output | 1 | Debug interface clock enable |
| pll_stop_ok | output | 1 | System may stop PLL and system clock |
| div2_sel | output | 1 | Half-rate core clock select |
| pstate | output | 3 | Current state code |

## Verification
The bench builds the sequencer with LOCK_CYCLES set to 5. This keeps the relock window short, so the bench can count every cycle of it, and many random visits to deep sleep fit into one run. The default of 64 would leave the same path unchanged but would spend most of the run waiting in relock. A window of 5 also exercises the counter's load and its expiry at the boundary. Random acknowledge and snoop levels, mixed with directed walks, drive each transition with wake events arriving in every state.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_WACK   = 3'd1,
    PS_NAP    = 3'd2,
    PS_DOZE   = 3'd3,
    PS_SLEEP  = 3'd4,
    PS_DEEP   = 3'd5,
    PS_RELOCK = 3'd6
  } pstate_e;

  typedef struct packed {
    logic fetch;
    logic units;
    logic snoop;
    logic timer;
    logic debug;
  } clk_en_t;

  // Maps a software request code to the low-power state it selects.
  function automatic pstate_e target_of(input logic [1:0] code);
    case (code)
      2'd1:    return PS_NAP;
      2'd2:    return PS_SLEEP;
      2'd3:    return PS_DEEP;
      default: return PS_RUN;
    endcase
  endfunction

endpackage

// File: rtl/pss_lock_timer.sv
module pss_lock_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= LOAD_VAL;
    else if (run && cnt != '0)     cnt <= cnt - 1'b1;
  end

  // The final cycle of the window is the one where one count remains.
  assign done = (cnt <= CW'(1));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD_VAL);

  assert_load_starts_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == LOAD_VAL));

endmodule

// File: rtl/pss_enable_map.sv
module pss_enable_map
  import pss_pkg::*;
(
  input  pstate_e state,
  output clk_en_t en,
  output logic    qreq,
  output logic    pll_ok
);
  always_comb begin
    en     = '0;
    qreq   = 1'b0;
    pll_ok = 1'b0;
    case (state)
      PS_RUN:    en = 5'b11111;
      PS_WACK: begin en = 5'b01111; qreq = 1'b1; end
      PS_NAP:  begin en = 5'b00011; qreq = 1'b1; end
      PS_DOZE: begin en = 5'b00111; qreq = 1'b1; end
      PS_SLEEP:  qreq = 1'b1;
      PS_DEEP: begin qreq = 1'b1; pll_ok = 1'b1; end
      default:   en = '0;
    endcase
  end
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_code,
  input  logic       half_req,
  input  logic       qack,
  input  logic       snoop_req,
  input  logic       wake_irq,
  input  logic       wake_mchk,
  input  logic       wake_rst,
  output logic       qreq,
  output logic       en_fetch,
  output logic       en_units,
  output logic       en_snoop,
  output logic       en_timer,
  output logic       en_debug,
  output logic       pll_stop_ok,
  output logic       div2_sel,
  output logic [2:0] pstate
);
  pstate_e state, state_nx;
  pstate_e tgt;
  clk_en_t en;
  logic    wake, lk_done, lk_load;

  assign wake = wake_irq | wake_mchk | wake_rst;

  always_comb begin
    state_nx = state;
    case (state)
      PS_RUN:    if (cmd_wr && cmd_code != 2'd0) state_nx = PS_WACK;
      PS_WACK:   if (wake) state_nx = PS_RUN;
                 else if (qack) state_nx = tgt;
      PS_NAP:    if (wake) state_nx = PS_RUN;
                 else if (snoop_req) state_nx = PS_DOZE;
      PS_DOZE:   if (wake) state_nx = PS_RUN;
                 else if (!snoop_req) state_nx = PS_NAP;
      PS_SLEEP:  if (wake) state_nx = PS_RUN;
      PS_DEEP:   if (wake) state_nx = PS_RELOCK;
      PS_RELOCK: if (lk_done) state_nx = PS_RUN;
      default:   state_nx = PS_RUN;
    endcase
  end

  assign lk_load = (state == PS_DEEP) && wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PS_RUN;
      tgt      <= PS_RUN;
      div2_sel <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == PS_RUN && cmd_wr) tgt <= target_of(cmd_code);
      if (state == PS_RUN)           div2_sel <= half_req;
      else if (lk_load)              div2_sel <= 1'b0;
    end
  end

  pss_lock_timer #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (lk_load),
    .run   (state == PS_RELOCK),
    .done  (lk_done)
  );

  pss_enable_map u_map (
    .state  (state),
    .en     (en),
    .qreq   (qreq),
    .pll_ok (pll_stop_ok)
  );

  assign en_fetch = en.fetch;
  assign en_units = en.units;
  assign en_snoop = en.snoop;
  assign en_timer = en.timer;
  assign en_debug = en.debug;
  assign pstate   = state;

  assert_ack_before_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PS_WACK && state != PS_WACK && state != PS_RUN) |-> $past(qack));

  assert_wake_returns_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state inside {PS_WACK, PS_NAP, PS_DOZE, PS_SLEEP}) && wake) |=> (pstate == 3'd0 && !qreq));

  assert_relock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RELOCK && !lk_done) |=> (state == PS_RELOCK));

  assert_sleep_ignores_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SLEEP && !wake) |=> (state == PS_SLEEP && !en_snoop));

  assert_div2_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {PS_WACK, PS_NAP, PS_DOZE, PS_SLEEP}) |=> $stable(div2_sel));

endmodule

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, half_req = 0, qack = 0, snoop_req = 0;
  logic wake_irq = 0, wake_mchk = 0, wake_rst = 0;
  logic [1:0] cmd_code = 0;
  logic qreq, en_fetch, en_units, en_snoop, en_timer, en_debug, pll_stop_ok, div2_sel;
  logic [2:0] pstate;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  // bench reference model state
  int m_state = 0, m_tgt = 0, m_cnt = 0;
  bit m_div2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_seq #(.LOCK_CYCLES(LK)) dut (
    .clk, .rst_n, .cmd_wr, .cmd_code, .half_req, .qack, .snoop_req,
    .wake_irq, .wake_mchk, .wake_rst, .qreq, .en_fetch, .en_units, .en_snoop,
    .en_timer, .en_debug, .pll_stop_ok, .div2_sel, .pstate);

  function automatic logic [4:0] exp_en(input int s);
    case (s)
      0: return 5'b11111;
      1: return 5'b01111;
      2: return 5'b00011;
      3: return 5'b00111;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic bit exp_qreq(input int s);
    return (s >= 1 && s <= 5);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    check({tag, " state"}, 32'(pstate), 32'(m_state));
    check({tag, " enables"}, 32'({en_fetch, en_units, en_snoop, en_timer, en_debug}), 32'(exp_en(m_state)));
    check({tag, " qreq"}, 32'(qreq), 32'(exp_qreq(m_state)));
    check({tag, " pll_stop_ok"}, 32'(pll_stop_ok), 32'(m_state == 5));
    check({tag, " div2_sel"}, 32'(div2_sel), 32'(m_div2));
  endtask

  task automatic step(input bit cw, input logic [1:0] code, input bit ack, input bit snp,
                      input bit wi, input bit wm, input bit wr, input bit half);
    int ns;
    bit wk;
    cmd_wr = cw; cmd_code = code; qack = ack; snoop_req = snp;
    wake_irq = wi; wake_mchk = wm; wake_rst = wr; half_req = half;
    wk = wi | wm | wr;
    ns = m_state;
    case (m_state)
      0: if (cw && code != 0) ns = 1;
      1: if (wk) ns = 0; else if (ack) ns = m_tgt;
      2: if (wk) ns = 0; else if (snp) ns = 3;
      3: if (wk) ns = 0; else if (!snp) ns = 2;
      4: if (wk) ns = 0;
      5: if (wk) ns = 6;
      6: if (m_cnt == 1) ns = 0;
      default: ns = 0;
    endcase
    if (m_state == 0 && cw) m_tgt = (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 5 : 0;
    if (m_state == 0) m_div2 = half;
    else if (m_state == 5 && wk) m_div2 = 0;
    if (m_state == 5 && wk) m_cnt = LK;
    else if (m_state == 6 && m_cnt > 0) m_cnt--;
    @(posedge clk);
    #1;
    m_state = ns;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, half_req);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    check_model("R1 reset");
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 state after release", 32'(pstate), 0);

    // R2: code 0 ignored
    step(1, 0, 0, 0, 0, 0, 0, 0);
    check("R2 code0 no effect", 32'(pstate), 0);
    // R2/R3: nap request, hold qack low
    step(1, 1, 0, 0, 0, 0, 0, 0);
    check("R2 await ack", 32'(pstate), 1);
    check("R2 qreq high", 32'(qreq), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R3 stays waiting without ack", 32'(pstate), 1);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R3 enter nap on ack", 32'(pstate), 2);
    check("R4 nap enables", 32'({en_fetch, en_units, en_snoop, en_timer, en_debug}), 32'b00011);
    // R11: write while napping
    step(1, 2, 1, 0, 0, 0, 0, 0);
    check("R11 write ignored in nap", 32'(pstate), 2);
    // R5: snoop to doze and back
    step(0, 0, 1, 1, 0, 0, 0, 0);
    check("R5 doze on snoop", 32'(pstate), 3);
    check("R5 snoop enable in doze", 32'(en_snoop), 1);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R5 back to nap", 32'(pstate), 2);
    // R8: wake from nap
    step(0, 0, 1, 0, 1, 0, 0, 0);
    check("R8 run after irq", 32'(pstate), 0);
    check("R8 qreq low", 32'(qreq), 0);
    // R6: sleep ignores snoop
    step(1, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R6 in sleep", 32'(pstate), 4);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    check("R6 snoop ignored", 32'(pstate), 4);
    check("R6 snoop enable low", 32'(en_snoop), 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    check("R8 run after machine check", 32'(pstate), 0);
    // R8: wake while awaiting ack
    step(1, 3, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    check("R8 abort wait on reset request", 32'(pstate), 0);
    // R10 / R7 / R9: half rate, deep sleep, relock
    step(0, 0, 0, 0, 0, 0, 0, 1);
    check("R10 div2 follows in run", 32'(div2_sel), 1);
    step(1, 3, 0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    check("R7 deep sleep", 32'(pstate), 5);
    check("R7 pll stop allowed", 32'(pll_stop_ok), 1);
    check("R10 div2 held outside run", 32'(div2_sel), 1);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    check("R10 div2 cleared on relock", 32'(div2_sel), 0);
    for (int i = 0; i < LK; i++) begin
      check("R9 relock window", 32'(pstate), 6);
      check("R9 enables off", 32'({en_fetch, en_units, en_snoop, en_timer, en_debug}), 0);
      idle();
    end
    check("R9 run after window", 32'(pstate), 0);
    check_model("R9 model after relock");

    // random phase against bench model
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, 2'($urandom), $urandom % 2, ($urandom % 3) == 0,
           ($urandom % 24) == 0, ($urandom % 40) == 0, ($urandom % 40) == 0, $urandom % 2);
      check_model("RND");
    end
    finish_run();
  end
endmodule